// File: doc/BRIEF.md
# Triggered DAC sample buffer sequencer

This block is the digital front end of a DAC. It stores a small table of conversion codes, written and read through a byte-wide register port. A read pointer picks the table entry that drives the code output. The pointer moves one step for each trigger event, and the event comes either from a hardware trigger pin or from a software write.

The pointer runs between zero and a programmable upper limit in one of three patterns:
- wrapping back to zero;
- sweeping up and down;
- stopping at the limit.

Three status flags record three pointer conditions: reaching zero, reaching the limit, and reaching a watermark a short distance below the limit. Each flag has its own enable. One control bit sends the enabled flags either to an interrupt line or to a DMA request line. Completion of a DMA transfer clears the flags.

The reference-select and low-power bits are kept only as storage, for the analog macro to use.

Top module: `dac_seq_top`

Register map, with B = 2·ENTRIES (0x20 at the defaults):

| Byte | Contents |
|---|---|
| 0 .. B−1 | The table. Entry i has its low byte at 2i, and its upper CODE_W−8 bits in the low bits of byte 2i+1. |
| B (control A) | bit0 module enable; bit1 trigger select (1 = software, 0 = hardware pin); bit2 software trigger, write-only; bit3 reference select; bit4 low power; bit5 top-flag enable; bit6 bottom-flag enable; bit7 watermark-flag enable. |
| B+1 (control B) | bit0 buffer enable; bits 2:1 traversal mode (00 wrap, 01 swing, 10 one-shot, 11 reserved/hold); bits 4:3 watermark distance minus one; bit7 DMA routing. |
| B+2 (pointer/limit) | Low nibble is the upper limit; high nibble is the read pointer. |
| B+3 (status) | bit0 top flag (pointer is 0); bit1 bottom flag (pointer equals limit); bit2 watermark flag. |

## Requirements
- R1: After reset every table entry is 0, the code output is 0, both control bytes read 0x00, the pointer/limit byte reads 0x0F (limit ENTRIES−1, pointer 0), the status byte reads 0x01 (top flag set), and irq and dma_req are low.
- R2: A write to byte 2i sets the low 8 bits of entry i. A write to byte 2i+1 sets bits CODE_W−1..8 of entry i. Reading byte 2i+1 returns those bits, with the unused upper bits of the byte reading 0.
- R3: With the buffer enable (control B bit0) clear, the code output is entry 0. With it set, the code output is the entry the pointer selects. A write to the pointer/limit byte loads both fields at once, and a pointer value above the new limit is clamped to the limit.
- R4: In wrap mode (00) a step from the limit moves the pointer to 0, and any other step adds one.
- R5: In swing mode (01) the pointer counts up until it reaches the limit, then counts down until it reaches 0, then counts up again. Each reversal takes one step.
- R6: In one-shot mode (10) the pointer stops at the limit and further steps leave it there. In the reserved mode (11) steps do not move the pointer.
- R7: A step happens only while both the module enable and the buffer enable are set. With the trigger select at 1, writing 1 to control A bit2 gives exactly one step, and the pin is ignored. With the trigger select at 0, each rising edge of hw_trig gives exactly one step, and the software bit is ignored. Control A bit2 always reads 0.
- R8: While the module enable is clear, software writes and pin edges leave the pointer unchanged.
- R9: The top and bottom flags set one clock after their condition becomes true, and only on that change. Writing a 0 to a status bit clears that flag; writing a 1 leaves it unchanged.
- R10: The watermark flag sets one clock after the pointer becomes equal to limit − (control B bits 4:3 + 1). It never sets when the limit is smaller than that distance.
- R11: When a set flag has its enable set, the block raises irq if DMA routing is clear and dma_req if it is set. The two lines are never high together, and a dma_done pulse clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (6) | Register byte address |
| reg_wr | input | 1 | Write strobe for the byte at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the byte at reg_addr, combinational |
| hw_trig | input | 1 | Hardware trigger pin |
| dma_done | input | 1 | DMA completion pulse; clears the flags |
| dac_code | output | CODE_W (12) | Code driven to the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench builds the block with its defaults: 16 entries, 12-bit codes, and rising-edge detection on the trigger pin. With 16 entries the pointer and limit fill both nibbles of their shared byte. This makes the clamp at a lowered limit, the reset value 0x0F, and a watermark four words below a limit of 15 all reachable. The edge-detecting variant is the one that lets a pin held high for several clocks prove that it produces a single step.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   typedef enum logic [1:0] {
      TRAV_WRAP  = 2'b00,
      TRAV_SWING = 2'b01,
      TRAV_ONCE  = 2'b10,
      TRAV_HOLD  = 2'b11
   } trav_mode_e;

   // Offsets of the control bytes above the table area
   localparam int OFS_CTRL_A = 0;
   localparam int OFS_CTRL_B = 1;
   localparam int OFS_PTRLIM = 2;
   localparam int OFS_STATUS = 3;

   // Flag vector bit positions
   localparam int FLG_TOP = 0;
   localparam int FLG_BOT = 1;
   localparam int FLG_WM  = 2;
   localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/dac_seq_buffer.sv
module dac_seq_buffer #(
   parameter int ENTRIES = 16,
   parameter int CODE_W  = 12,
   localparam int PTR_W  = $clog2(ENTRIES),
   localparam int HI_W   = CODE_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic              wr_hi,
   input  logic [7:0]        wr_data,
   input  logic [PTR_W-1:0]  rd_idx,
   input  logic              rd_hi,
   output logic [7:0]        rd_byte,
   input  logic [PTR_W-1:0]  sel_idx,
   output logic [CODE_W-1:0] code
);

   logic [ENTRIES-1:0][CODE_W-1:0] words;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [CODE_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && (wr_idx == PTR_W'(i))) begin
            if (wr_hi) word_q[CODE_W-1:8] <= wr_data[HI_W-1:0];
            else       word_q[7:0]        <= wr_data;
         end
      end
      assign words[i] = word_q;
   end

   logic [15:0] rd_ext;
   always_comb begin
      rd_ext  = 16'(words[rd_idx]);
      rd_byte = rd_hi ? rd_ext[15:8] : rd_ext[7:0];
   end

   assign code = words[sel_idx];

endmodule

// File: rtl/dac_seq_pointer.sv
module dac_seq_pointer
   import dac_seq_pkg::*;
#(
   parameter int ENTRIES   = 16,
   parameter bit TRIG_EDGE = 1'b1,
   localparam int PTR_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             sw_sel,
   input  logic             sw_pulse,
   input  logic             hw_trig,
   input  trav_mode_e       mode,
   input  logic             load,
   input  logic [PTR_W-1:0] load_lim,
   input  logic [PTR_W-1:0] load_ptr,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] limit,
   output logic             step
);

   logic hw_evt;

   if (TRIG_EDGE) begin : g_edge
      logic hw_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hw_q <= 1'b0;
         else        hw_q <= hw_trig;
      end
      assign hw_evt = hw_trig & ~hw_q;
   end else begin : g_level
      assign hw_evt = hw_trig;
   end

   assign step = run_en & (sw_sel ? sw_pulse : hw_evt);

   logic [PTR_W-1:0] ptr_q, lim_q, ptr_nxt;
   logic             dir_dn_q, dir_dn_nxt;
   logic             at_lim, at_zero;

   assign at_lim  = (ptr_q >= lim_q);
   assign at_zero = (ptr_q == '0);

   always_comb begin
      ptr_nxt    = ptr_q;
      dir_dn_nxt = dir_dn_q;
      case (mode)
         TRAV_WRAP:  ptr_nxt = at_lim ? '0 : ptr_q + 1'b1;
         TRAV_ONCE:  ptr_nxt = at_lim ? lim_q : ptr_q + 1'b1;
         TRAV_SWING: begin
            if (dir_dn_q) begin
               if (at_zero) begin
                  ptr_nxt    = (lim_q == '0) ? '0 : ptr_q + 1'b1;
                  dir_dn_nxt = 1'b0;
               end else begin
                  ptr_nxt = ptr_q - 1'b1;
               end
            end else begin
               if (at_lim) begin
                  ptr_nxt    = at_zero ? '0 : ptr_q - 1'b1;
                  dir_dn_nxt = 1'b1;
               end else begin
                  ptr_nxt = ptr_q + 1'b1;
               end
            end
         end
         default: ptr_nxt = ptr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         lim_q    <= PTR_W'(ENTRIES - 1);
         dir_dn_q <= 1'b0;
      end else if (load) begin
         lim_q <= load_lim;
         ptr_q <= (load_ptr > load_lim) ? load_lim : load_ptr;
      end else if (step) begin
         ptr_q    <= ptr_nxt;
         dir_dn_q <= dir_dn_nxt;
      end
   end

   assign ptr   = ptr_q;
   assign limit = lim_q;

endmodule

// File: rtl/dac_seq_flags.sv
module dac_seq_flags
   import dac_seq_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int PTR_W  = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PTR_W-1:0]     ptr,
   input  logic [PTR_W-1:0]     limit,
   input  logic [1:0]           wm_sel,
   input  logic                 clr_wr,
   input  logic [NUM_FLAGS-1:0] clr_keep,
   input  logic                 dma_done,
   input  logic [NUM_FLAGS-1:0] flag_en,
   input  logic                 dma_mode,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 irq,
   output logic                 dma_req
);

   // Condition values right after reset: pointer 0, limit ENTRIES-1, distance 1
   localparam logic [NUM_FLAGS-1:0] COND_RST = {(ENTRIES - 1) == 1, 1'b0, 1'b1};

   logic [NUM_FLAGS-1:0] cond, cond_q, flag_q, flag_d;
   int lim_i, ptr_i, dist_i;

   always_comb begin
      lim_i  = int'(limit);
      ptr_i  = int'(ptr);
      dist_i = int'(wm_sel) + 1;
      cond[FLG_TOP] = (ptr == '0);
      cond[FLG_BOT] = (ptr == limit);
      cond[FLG_WM]  = (lim_i >= dist_i) && (ptr_i == lim_i - dist_i);
   end

   always_comb begin
      flag_d = flag_q;
      if (dma_done) flag_d = '0;
      if (clr_wr)   flag_d = flag_d & clr_keep;
      flag_d = flag_d | (cond & ~cond_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= COND_RST;
         flag_q <= NUM_FLAGS'(1 << FLG_TOP);
      end else begin
         cond_q <= cond;
         flag_q <= flag_d;
      end
   end

   logic any_req;
   assign any_req = |(flag_q & flag_en);
   assign irq     = any_req & ~dma_mode;
   assign dma_req = any_req & dma_mode;
   assign flags   = flag_q;

endmodule

// File: rtl/dac_seq_top.sv
module dac_seq_top
   import dac_seq_pkg::*;
#(
   parameter int ENTRIES   = 16,
   parameter int CODE_W    = 12,
   parameter bit TRIG_EDGE = 1'b1,
   localparam int PTR_W      = $clog2(ENTRIES),
   localparam int DATA_BYTES = 2 * ENTRIES,
   localparam int ADDR_W     = $clog2(DATA_BYTES + 4),
   localparam int REG_BASE   = DATA_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              hw_trig,
   input  logic              dma_done,
   output logic [CODE_W-1:0] dac_code,
   output logic              irq,
   output logic              dma_req
);

   if (ENTRIES < 2 || ENTRIES > 16 || (1 << PTR_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two from 2 to 16");
   end
   if (CODE_W < 9 || CODE_W > 16) begin : g_bad_code_w
      $error("CODE_W must lie between 9 and 16");
   end

   localparam logic [ADDR_W-1:0] A_CTRL_A = ADDR_W'(REG_BASE + OFS_CTRL_A);
   localparam logic [ADDR_W-1:0] A_CTRL_B = ADDR_W'(REG_BASE + OFS_CTRL_B);
   localparam logic [ADDR_W-1:0] A_PTRLIM = ADDR_W'(REG_BASE + OFS_PTRLIM);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_BASE + OFS_STATUS);

   logic [7:0] ctrl_a_q, ctrl_b_q;
   logic       in_table, wr_ctrl_a, wr_ctrl_b, wr_pl, wr_st, sw_pulse;

   assign in_table  = (reg_addr < ADDR_W'(DATA_BYTES));
   assign wr_ctrl_a = reg_wr && (reg_addr == A_CTRL_A);
   assign wr_ctrl_b = reg_wr && (reg_addr == A_CTRL_B);
   assign wr_pl     = reg_wr && (reg_addr == A_PTRLIM);
   assign wr_st     = reg_wr && (reg_addr == A_STATUS);
   assign sw_pulse  = wr_ctrl_a && reg_wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_a_q <= '0;
         ctrl_b_q <= '0;
      end else begin
         if (wr_ctrl_a) ctrl_a_q <= reg_wdata & 8'hFB;
         if (wr_ctrl_b) ctrl_b_q <= reg_wdata & 8'h9F;
      end
   end

   logic             mod_en, trig_sw, buf_en, dma_mode;
   logic [2:0]       flag_en;
   trav_mode_e       mode;
   logic [1:0]       wm_sel;

   assign mod_en   = ctrl_a_q[0];
   assign trig_sw  = ctrl_a_q[1];
   assign flag_en  = ctrl_a_q[7:5];
   assign buf_en   = ctrl_b_q[0];
   assign mode     = trav_mode_e'(ctrl_b_q[2:1]);
   assign wm_sel   = ctrl_b_q[4:3];
   assign dma_mode = ctrl_b_q[7];

   logic [PTR_W-1:0]     ptr, limit;
   logic                 step;
   logic [NUM_FLAGS-1:0] flags;
   logic [7:0]           tbl_byte;

   dac_seq_buffer #(.ENTRIES(ENTRIES), .CODE_W(CODE_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && in_table),
      .wr_idx  (reg_addr[PTR_W:1]),
      .wr_hi   (reg_addr[0]),
      .wr_data (reg_wdata),
      .rd_idx  (reg_addr[PTR_W:1]),
      .rd_hi   (reg_addr[0]),
      .rd_byte (tbl_byte),
      .sel_idx (buf_en ? ptr : '0),
      .code    (dac_code)
   );

   dac_seq_pointer #(.ENTRIES(ENTRIES), .TRIG_EDGE(TRIG_EDGE)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (mod_en && buf_en),
      .sw_sel   (trig_sw),
      .sw_pulse (sw_pulse),
      .hw_trig  (hw_trig),
      .mode     (mode),
      .load     (wr_pl),
      .load_lim (reg_wdata[PTR_W-1:0]),
      .load_ptr (reg_wdata[4 +: PTR_W]),
      .ptr      (ptr),
      .limit    (limit),
      .step     (step)
   );

   dac_seq_flags #(.ENTRIES(ENTRIES)) u_flg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr      (ptr),
      .limit    (limit),
      .wm_sel   (wm_sel),
      .clr_wr   (wr_st),
      .clr_keep (reg_wdata[NUM_FLAGS-1:0]),
      .dma_done (dma_done),
      .flag_en  (flag_en),
      .dma_mode (dma_mode),
      .flags    (flags),
      .irq      (irq),
      .dma_req  (dma_req)
   );

   always_comb begin
      if (in_table)                   reg_rdata = tbl_byte;
      else if (reg_addr == A_CTRL_A)  reg_rdata = ctrl_a_q;
      else if (reg_addr == A_CTRL_B)  reg_rdata = ctrl_b_q;
      else if (reg_addr == A_PTRLIM)  reg_rdata = {4'(ptr), 4'(limit)};
      else if (reg_addr == A_STATUS)  reg_rdata = 8'(flags);
      else                            reg_rdata = '0;
   end

endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker
   import dac_seq_pkg::*;
#(
   parameter int PTR_W    = 4,
   parameter int ADDR_W   = 6,
   parameter int REG_BASE = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PTR_W-1:0]  ptr,
   input logic [PTR_W-1:0]  limit,
   input logic              step,
   input logic              wr_pl,
   input logic              mod_en,
   input trav_mode_e        mode,
   input logic              irq,
   input logic              dma_req,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_rdata
);

   // R3: the pointer never passes the limit
   p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= limit);

   // R4: wrap mode returns to zero after the limit
   p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRAV_WRAP && step && !wr_pl && ptr == limit) |=> (ptr == '0));

   // R6: one-shot parks at the limit
   p_once_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRAV_ONCE && !wr_pl && ptr == limit) |=> $stable(ptr));

   // R6: reserved mode never moves the pointer
   p_hold_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRAV_HOLD && !wr_pl) |=> $stable(ptr));

   // R8: disabled module keeps the pointer
   p_disabled_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_en && !wr_pl) |=> $stable(ptr));

   // R7: the software trigger bit never reads back as 1
   p_swtrig_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(REG_BASE + OFS_CTRL_A)) |-> !reg_rdata[2]);

   // R11: interrupt and DMA request are exclusive
   p_route_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && dma_req));

endmodule

bind dac_seq_top dac_seq_checker #(
   .PTR_W    (PTR_W),
   .ADDR_W   (ADDR_W),
   .REG_BASE (REG_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ptr       (ptr),
   .limit     (limit),
   .step      (step),
   .wr_pl     (wr_pl),
   .mod_en    (mod_en),
   .mode      (mode),
   .irq       (irq),
   .dma_req   (dma_req),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata)
);

// File: tb/dac_seq_top_test.sv
`timescale 1ns/1ps
module dac_seq_top_test;

   localparam int ADDR_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic              reg_wr = 1'b0;
   logic [7:0]        reg_wdata = '0;
   logic [7:0]        reg_rdata;
   logic              hw_trig = 1'b0;
   logic              dma_done = 1'b0;
   logic [11:0]       dac_code;
   logic              irq, dma_req;

   dac_seq_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .hw_trig   (hw_trig),
      .dma_done  (dma_done),
      .dac_code  (dac_code),
      .irq       (irq),
      .dma_req   (dma_req)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Vector ops
   localparam logic [2:0] OW = 3'd0;  // register write
   localparam logic [2:0] OR = 3'd1;  // register read check
   localparam logic [2:0] OI = 3'd2;  // idle cycle
   localparam logic [2:0] OC = 3'd3;  // code output check
   localparam logic [2:0] OH = 3'd4;  // one-cycle pin pulse
   localparam logic [2:0] OP = 3'd5;  // pin high
   localparam logic [2:0] OL = 3'd6;  // pin low
   localparam logic [2:0] OQ = 3'd7;  // check {dma_req, irq}

   typedef struct packed {
      logic [2:0]  op;
      logic [7:0]  a;
      logic [11:0] d;
      logic [3:0]  r;
   } vec_t;

   localparam int NV = 90;
   localparam vec_t TBL [NV] = '{
      // R2: table writes and reads
      {OW, 8'h00, 12'h034, 4'd2}, {OW, 8'h01, 12'h0F2, 4'd2},
      {OR, 8'h01, 12'h002, 4'd2}, {OR, 8'h00, 12'h034, 4'd2},
      {OW, 8'h02, 12'h011, 4'd2}, {OW, 8'h03, 12'h001, 4'd2},
      {OW, 8'h04, 12'h022, 4'd2}, {OW, 8'h05, 12'h002, 4'd2},
      {OW, 8'h06, 12'h033, 4'd2}, {OW, 8'h07, 12'h003, 4'd2},
      {OW, 8'h08, 12'h044, 4'd2}, {OW, 8'h09, 12'h004, 4'd2},
      // R3: output selection
      {OC, 8'h00, 12'h234, 4'd3}, {OW, 8'h22, 12'h023, 4'd3},
      {OC, 8'h00, 12'h234, 4'd3}, {OW, 8'h21, 12'h001, 4'd3},
      {OC, 8'h00, 12'h222, 4'd3},
      // R7 software trigger, R4 stepping, R9 flags
      {OW, 8'h20, 12'h003, 4'd7}, {OW, 8'h20, 12'h007, 4'd7},
      {OR, 8'h22, 12'h033, 4'd4}, {OR, 8'h20, 12'h003, 4'd7},
      {OR, 8'h23, 12'h007, 4'd9}, {OW, 8'h23, 12'h000, 4'd9},
      {OR, 8'h23, 12'h000, 4'd9},
      {OW, 8'h20, 12'h007, 4'd4}, {OR, 8'h22, 12'h003, 4'd4},
      {OR, 8'h23, 12'h001, 4'd9}, {OW, 8'h23, 12'h006, 4'd9},
      {OR, 8'h23, 12'h000, 4'd9},
      // R10: watermark at limit-1
      {OW, 8'h20, 12'h007, 4'd4}, {OR, 8'h23, 12'h000, 4'd10},
      {OW, 8'h20, 12'h007, 4'd4}, {OI, 8'h00, 12'h000, 4'd10},
      {OR, 8'h23, 12'h004, 4'd10},
      {OW, 8'h23, 12'h004, 4'd9}, {OR, 8'h23, 12'h004, 4'd9},
      {OC, 8'h00, 12'h222, 4'd3},
      // R5: swing
      {OW, 8'h21, 12'h003, 4'd5}, {OW, 8'h20, 12'h007, 4'd5},
      {OR, 8'h22, 12'h033, 4'd5}, {OW, 8'h20, 12'h007, 4'd5},
      {OR, 8'h22, 12'h023, 4'd5}, {OW, 8'h20, 12'h007, 4'd5},
      {OW, 8'h20, 12'h007, 4'd5}, {OR, 8'h22, 12'h003, 4'd5},
      {OW, 8'h20, 12'h007, 4'd5}, {OR, 8'h22, 12'h013, 4'd5},
      // R6: one-shot and hold, R3 clamp
      {OW, 8'h21, 12'h005, 4'd6}, {OW, 8'h20, 12'h007, 4'd6},
      {OW, 8'h20, 12'h007, 4'd6}, {OW, 8'h20, 12'h007, 4'd6},
      {OR, 8'h22, 12'h033, 4'd6}, {OW, 8'h21, 12'h007, 4'd6},
      {OW, 8'h22, 12'h031, 4'd3}, {OR, 8'h22, 12'h011, 4'd3},
      {OW, 8'h20, 12'h007, 4'd6}, {OR, 8'h22, 12'h011, 4'd6},
      // R7: hardware trigger
      {OW, 8'h21, 12'h001, 4'd7}, {OW, 8'h22, 12'h003, 4'd7},
      {OW, 8'h20, 12'h001, 4'd7}, {OH, 8'h00, 12'h000, 4'd7},
      {OR, 8'h22, 12'h013, 4'd7}, {OW, 8'h20, 12'h005, 4'd7},
      {OR, 8'h22, 12'h013, 4'd7}, {OP, 8'h00, 12'h000, 4'd7},
      {OI, 8'h00, 12'h000, 4'd7}, {OI, 8'h00, 12'h000, 4'd7},
      {OL, 8'h00, 12'h000, 4'd7}, {OR, 8'h22, 12'h023, 4'd7},
      // R8: module disabled
      {OW, 8'h20, 12'h000, 4'd8}, {OH, 8'h00, 12'h000, 4'd8},
      {OR, 8'h22, 12'h023, 4'd8}, {OW, 8'h20, 12'h002, 4'd8},
      {OW, 8'h20, 12'h006, 4'd8}, {OR, 8'h22, 12'h023, 4'd8},
      // R7: buffer off blocks steps
      {OW, 8'h21, 12'h000, 4'd7}, {OW, 8'h20, 12'h003, 4'd7},
      {OW, 8'h20, 12'h007, 4'd7}, {OR, 8'h22, 12'h023, 4'd7},
      {OC, 8'h00, 12'h234, 4'd3},
      // R10: four words below limit 15
      {OW, 8'h21, 12'h019, 4'd10}, {OW, 8'h22, 12'h02F, 4'd10},
      {OW, 8'h23, 12'h000, 4'd10}, {OW, 8'h22, 12'h0BF, 4'd10},
      {OI, 8'h00, 12'h000, 4'd10}, {OR, 8'h23, 12'h004, 4'd10},
      // R11: routing
      {OW, 8'h20, 12'h080, 4'd11}, {OQ, 8'h00, 12'h001, 4'd11},
      {OW, 8'h21, 12'h099, 4'd11}, {OQ, 8'h00, 12'h002, 4'd11}
   };

   task automatic run_vec(input vec_t v);
      string tag;
      tag = $sformatf("R%0d vec a=0x%0h", v.r, v.a);
      case (v.op)
         OW: begin
            reg_addr = v.a[ADDR_W-1:0]; reg_wdata = v.d[7:0]; reg_wr = 1'b1;
            @(negedge clk); reg_wr = 1'b0;
         end
         OR: begin
            reg_addr = v.a[ADDR_W-1:0]; #1;
            chk(tag, int'(reg_rdata), int'(v.d[7:0]));
            @(negedge clk);
         end
         OC: begin #1; chk(tag, int'(dac_code), int'(v.d)); @(negedge clk); end
         OH: begin hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0; end
         OP: begin hw_trig = 1'b1; @(negedge clk); end
         OL: begin hw_trig = 1'b0; @(negedge clk); end
         OQ: begin #1; chk(tag, int'({dma_req, irq}), int'(v.d[1:0])); @(negedge clk); end
         default: @(negedge clk);
      endcase
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      reg_addr = a[ADDR_W-1:0]; #1;
      chk(req, int'(reg_rdata), int'(exp));
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(TBL[i]);

      // R11: DMA completion clears all flags and drops the request
      dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
      rd_chk("R11 status after dma_done", 8'h23, 8'h00);
      #1; chk("R11 lines after dma_done", int'({dma_req, irq}), 0);

      // R9: set has priority over a clearing write in the same cycle is not relied on;
      // a clear of a set flag with others written 1
      reg_addr = 6'h22; reg_wdata = 8'h0F; reg_wr = 1'b1; @(negedge clk); reg_wr = 1'b0;
      @(negedge clk);
      rd_chk("R9 top flag after pointer load to 0", 8'h23, 8'h01);
      reg_addr = 6'h23; reg_wdata = 8'hFE; reg_wr = 1'b1; @(negedge clk); reg_wr = 1'b0;
      rd_chk("R9 write 0 clears top, 1s ignored", 8'h23, 8'h00);

      // R1: reset state
      rst_n = 1'b0; @(negedge clk); @(negedge clk); rst_n = 1'b1; @(negedge clk);
      rd_chk("R1 status", 8'h23, 8'h01);
      rd_chk("R1 pointer/limit", 8'h22, 8'h0F);
      rd_chk("R1 control A", 8'h20, 8'h00);
      rd_chk("R1 control B", 8'h21, 8'h00);
      rd_chk("R1 entry 0 low", 8'h00, 8'h00);
      rd_chk("R1 entry 0 high", 8'h01, 8'h00);
      #1;
      chk("R1 code", int'(dac_code), 0);
      chk("R1 irq/dma", int'({dma_req, irq}), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule